// File: doc/BRIEF.md
# PCM receive multiframe sync generator

This block runs a receive timebase for a serial PCM stream. A bit counter steps through the bits of a frame and a frame counter steps through the frames of a multiframe, both on the receive clock. From these counts it produces a multiframe sync strobe. The strobe can be placed anywhere in the multiframe: a bit delay measured from the timebase's bit 0, followed by a frame delay measured in whole frames.

The frame length is chosen by a 2-bit select. The multiframe length, the bit delay and the frame delay are plain binary fields. The block latches all four settings together, either in reset or at the multiframe boundary. Software can therefore rewrite them at any time without producing a torn or doubled strobe. The current bit and frame counts are brought out for downstream slot logic.

Top module: `rx_msync_gen`

## Requirements
- R1: While `rst` is high, sampled on the rising clock edge, `bitCount` and `frameCount` read 0 and `syncOut` is low. The first cycle after release is bit 0 of frame 0.
- R2: `bitCount` counts up by one per clock and wraps to 0 after L-1, where L is set by `frameSel`: 0 gives 256, 1 gives 193, 2 gives 512 and 3 gives 256.
- R3: `frameCount` advances when `bitCount` wraps. It wraps to 0 after M-1, where M is `mfLen`, with `mfLen` = 0 meaning 64 frames.
- R4: The bit delay D is `bitLoc`, with 0 meaning 512. The strobe rises when `bitCount` equals (D-1) mod L, so `bitLoc` = 1 marks bit 0 and `bitLoc` = 2 marks bit 1, for every frame length.
- R5: A bit delay that reaches past the end of the frame carries into later frames. The strobe's frame is advanced by floor((D-1)/L).
- R6: The frame delay `frameLoc` is added after the bit delay and reduced modulo M. Overall the strobe sits at timebase position ((D-1) + frameLoc*L) mod (L*M), counted in clocks from bit 0 of frame 0.
- R7: `syncOut` is high for exactly one clock in each multiframe and never for two clocks in a row.
- R8: Changes to `frameSel`, `mfLen`, `bitLoc` and `frameLoc` take effect only from the next multiframe boundary (or on reset). A strobe position that moves later within the current multiframe does not fire before that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst | input | 1 | Synchronous reset, active high |
| frameSel | input | 2 | Frame length select (0:256, 1:193, 2:512, 3:256) |
| mfLen | input | 6 | Frames per multiframe, 0 means 64 |
| bitLoc | input | 9 | Bit delay of the strobe, 1..511, 0 means 512 |
| frameLoc | input | 6 | Frame delay of the strobe, applied after the bit delay |
| syncOut | output | 1 | One-clock multiframe sync strobe |
| bitCount | output | 9 | Current bit position in the frame |
| frameCount | output | 6 | Current frame position in the multiframe |

## Verification
The hardest case to reach is a settings write in the middle of a multiframe that moves the strobe to a position still ahead in that same multiframe. Only a design that applies the write at once would fire early there. The stimulus starts with the strobe at position 0. After about half a multiframe it rewrites the delays to a later position. The scoreboard then expects no strobe for the rest of that multiframe and the new position in every multiframe after it. The two-frame carry with 193-bit frames and the 512-bit delay encoded as 0 are reached through delay values chosen to spill past one and two frame ends.

// File: rtl/rx_msync_pkg.sv
package rx_msync_pkg;

  localparam int BIT_W = 9;
  localparam int FRM_W = 6;
  localparam int SEL_W = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic bitWrap;
    logic mfWrap;
    logic reload;
  } tbStrobe_t;

  // frame length in bits for a select code
  function automatic logic [BIT_W:0] frameBits(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd1:    return 10'd193;
      2'd2:    return 10'd512;
      default: return 10'd256;
    endcase
  endfunction

  // restoring remainder; result is always below the modulus (<= 64)
  function automatic logic [FRM_W-1:0] modSmall(input logic [FRM_W:0] a,
                                                input logic [FRM_W:0] m);
    logic [FRM_W+1:0] rem;
    rem = '0;
    for (int i = FRM_W; i >= 0; i--) begin
      rem = {rem[FRM_W:0], a[i]};
      if (rem >= {1'b0, m}) rem = rem - {1'b0, m};
    end
    return rem[FRM_W-1:0];
  endfunction

endpackage

// File: rtl/rx_msync_dp.sv
module rx_msync_dp
  import rx_msync_pkg::*;
#(
  parameter int BW = BIT_W,
  parameter int FW = FRM_W
) (
  input  logic          clk,
  input  logic          rst,
  input  tbStrobe_t     strb,
  input  logic [1:0]    frameSel,
  input  logic [FW-1:0] mfLen,
  input  logic [BW-1:0] bitLoc,
  input  logic [FW-1:0] frameLoc,
  output logic [BW-1:0] bitCnt,
  output logic [FW-1:0] frameCnt,
  output logic [BW-1:0] lenM1,
  output logic [FW-1:0] mfM1,
  output logic [BW-1:0] bitTgt,
  output logic [FW-1:0] frameTgt
);

  logic [BW:0]   lenFull;
  logic [BW+1:0] lenX, len2X, posX;
  logic [BW-1:0] len9, len2x9, bitPos, bitTgtNext;
  logic [1:0]    carry;
  logic [FW:0]   mfMod, sumF;

  always_comb begin
    lenFull = frameBits(frameSel);
    lenX    = {1'b0, lenFull};
    len2X   = {lenFull, 1'b0};
    len9    = lenFull[BW-1:0];
    len2x9  = {lenFull[BW-2:0], 1'b0};
    bitPos  = bitLoc - {{(BW-1){1'b0}}, 1'b1};   // 0 encodes 512 -> 511
    posX    = {2'b00, bitPos};
    if (posX >= len2X) begin
      carry      = 2'd2;
      bitTgtNext = bitPos - len2x9;
    end else if (posX >= lenX) begin
      carry      = 2'd1;
      bitTgtNext = bitPos - len9;
    end else begin
      carry      = 2'd0;
      bitTgtNext = bitPos;
    end
    mfMod = (mfLen == '0) ? (FW+1)'(1 << FW) : {1'b0, mfLen};
    sumF  = {1'b0, frameLoc} + {{(FW-1){1'b0}}, carry};
  end

  // settings register, loaded in reset or at the multiframe boundary
  always_ff @(posedge clk) begin
    if (strb.reload) begin
      lenM1    <= len9 - {{(BW-1){1'b0}}, 1'b1};
      mfM1     <= mfLen - {{(FW-1){1'b0}}, 1'b1};
      bitTgt   <= bitTgtNext;
      frameTgt <= modSmall(sumF, mfMod);
    end
  end

  // timebase counters
  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt   <= '0;
      frameCnt <= '0;
    end else if (strb.bitWrap) begin
      bitCnt   <= '0;
      frameCnt <= strb.mfWrap ? '0 : frameCnt + 1'b1;
    end else begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (bitCnt == '0 && frameCnt == '0));

  assert_bit_range_R2: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= lenM1);

  assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    strb.mfWrap |=> (frameCnt == '0 && bitCnt == '0));

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !strb.reload |=> ($stable(bitTgt) && $stable(frameTgt) &&
                      $stable(lenM1) && $stable(mfM1)));

endmodule

// File: rtl/rx_msync_ctrl.sv
module rx_msync_ctrl
  import rx_msync_pkg::*;
#(
  parameter int BW = BIT_W,
  parameter int FW = FRM_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] bitCnt,
  input  logic [FW-1:0] frameCnt,
  input  logic [BW-1:0] lenM1,
  input  logic [FW-1:0] mfM1,
  input  logic [BW-1:0] bitTgt,
  input  logic [FW-1:0] frameTgt,
  output tbStrobe_t     strb,
  output logic          syncOut
);

  always_comb begin
    strb.bitWrap = (bitCnt == lenM1);
    strb.mfWrap  = strb.bitWrap && (frameCnt == mfM1);
    strb.reload  = rst || strb.mfWrap;
    syncOut      = !rst && (bitCnt == bitTgt) && (frameCnt == frameTgt);
  end

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    syncOut |=> !syncOut);

  assert_sync_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
    syncOut |-> (frameCnt <= mfM1 && bitCnt <= lenM1));

endmodule

// File: rtl/rx_msync_gen.sv
module rx_msync_gen
  import rx_msync_pkg::*;
#(
  parameter int BW = BIT_W,
  parameter int FW = FRM_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    frameSel,
  input  logic [FW-1:0] mfLen,
  input  logic [BW-1:0] bitLoc,
  input  logic [FW-1:0] frameLoc,
  output logic          syncOut,
  output logic [BW-1:0] bitCount,
  output logic [FW-1:0] frameCount
);

  tbStrobe_t     strb;
  logic [BW-1:0] lenM1, bitTgt;
  logic [FW-1:0] mfM1, frameTgt;

  rx_msync_dp #(.BW(BW), .FW(FW)) uDp (
    .clk(clk), .rst(rst), .strb(strb),
    .frameSel(frameSel), .mfLen(mfLen), .bitLoc(bitLoc), .frameLoc(frameLoc),
    .bitCnt(bitCount), .frameCnt(frameCount),
    .lenM1(lenM1), .mfM1(mfM1), .bitTgt(bitTgt), .frameTgt(frameTgt)
  );

  rx_msync_ctrl #(.BW(BW), .FW(FW)) uCtrl (
    .clk(clk), .rst(rst),
    .bitCnt(bitCount), .frameCnt(frameCount),
    .lenM1(lenM1), .mfM1(mfM1), .bitTgt(bitTgt), .frameTgt(frameTgt),
    .strb(strb), .syncOut(syncOut)
  );

endmodule

// File: tb/rx_msync_gen_test.sv
module rx_msync_gen_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] frameSel = '0;
  logic [5:0] mfLen = 6'd16;
  logic [8:0] bitLoc = 9'd1;
  logic [5:0] frameLoc = '0;
  logic       syncOut;
  logic [8:0] bitCount;
  logic [5:0] frameCount;

  int total = 0;
  int bad = 0;
  int k = -1;
  int curL = 256;
  int curM = 16;
  string tagNow = "R4";
  int expQ[$];

  always #10 clk = ~clk;   // 50 MHz

  rx_msync_gen uut (
    .clk(clk), .rst(rst), .frameSel(frameSel), .mfLen(mfLen),
    .bitLoc(bitLoc), .frameLoc(frameLoc),
    .syncOut(syncOut), .bitCount(bitCount), .frameCount(frameCount)
  );

  // monitor: timebase check and scoreboard pop
  always @(negedge clk) begin
    if (rst) begin
      k = -1;
    end else begin
      k = k + 1;
      total++;
      if (int'(bitCount) != k % curL) begin
        bad++;
        $display("FAIL R2 k=%0d bitCount=%0d expected=%0d", k, bitCount, k % curL);
      end
      total++;
      if (int'(frameCount) != (k / curL) % curM) begin
        bad++;
        $display("FAIL R3 k=%0d frameCount=%0d expected=%0d", k, frameCount, (k / curL) % curM);
      end
      if (syncOut) begin
        total++;
        if (expQ.size() == 0) begin
          bad++;
          $display("FAIL R7 unexpected strobe at k=%0d expected=none", k);
        end else begin
          int e;
          e = expQ.pop_front();
          if (e != k) begin
            bad++;
            $display("FAIL %s strobe at k=%0d expected=%0d", tagNow, k, e);
          end
        end
      end
    end
  end

  task automatic checkReset();
    total++;
    if (bitCount != 0 || frameCount != 0 || syncOut !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset state bit=%0d frame=%0d sync=%0b expected=0/0/0",
               bitCount, frameCount, syncOut);
    end
  endtask

  task automatic checkDrained(input int endK);
    wait (k == endK);
    #1;
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL %s missing strobes=%0d expected=0 (next at %0d)",
               tagNow, expQ.size(), expQ[0]);
    end
  endtask

  task automatic startRun(input logic [1:0] sel, input int len, input int mf,
                          input int bl, input int fl, input int nPer, input string tag);
    int m, d, t, p;
    m = (mf == 0) ? 64 : mf;
    d = (bl == 0) ? 512 : bl;
    t = len * m;
    p = ((d - 1) + fl * len) % t;
    @(negedge clk);
    rst = 1'b1;
    frameSel = sel; mfLen = 6'(mf); bitLoc = 9'(bl); frameLoc = 6'(fl);
    curL = len; curM = m; tagNow = tag;
    expQ.delete();
    for (int i = 0; i < nPer; i++) expQ.push_back(p + i * t);
    repeat (3) @(negedge clk);
    checkReset();
    @(posedge clk);
    #2 rst = 1'b0;
  endtask

  task automatic runCase(input logic [1:0] sel, input int len, input int mf,
                         input int bl, input int fl, input int nPer, input string tag);
    startRun(sel, len, mf, bl, fl, nPer, tag);
    checkDrained(nPer * len * ((mf == 0) ? 64 : mf) - 1);
  endtask

  initial begin
    // R4: 256-bit frames, bitLoc 1 marks bit 0 of frame 0
    runCase(2'd0, 256, 16, 1, 0, 2, "R4");
    // R4: 193-bit frames, bitLoc 2 marks bit 1, R6 frame delay 3
    runCase(2'd1, 193, 12, 2, 3, 2, "R6");
    // R4: 512-bit frames, bitLoc 0 encodes a 512 delay, then frame delay 1
    runCase(2'd2, 512, 4, 0, 1, 2, "R4");
    // R5: delay 450 on 193-bit frames carries two frames, R6 wraps mod 24
    runCase(2'd1, 193, 24, 450, 23, 2, "R5");
    // R3/R5: select 3 is 256 bits, mfLen 0 is 64 frames, carry then wrap
    runCase(2'd3, 256, 0, 300, 63, 2, "R5");

    // R8: move the strobe later in the middle of a multiframe
    startRun(2'd0, 256, 16, 1, 0, 1, "R8");
    expQ.push_back(4096 + 2660);
    expQ.push_back(8192 + 2660);
    wait (k == 2000);
    #1;
    bitLoc = 9'd101;
    frameLoc = 6'd10;
    checkDrained(3 * 4096 - 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    total++;
    bad++;
    $display("FAIL watchdog expired at k=%0d expected=completion", k);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule